// File: doc/BRIEF.md
# AXI Write Path Width Halver (64-bit to 32-bit)

This block joins a 64-bit AXI write slave port to a 32-bit AXI write master port. It covers the write address, write data and write response channels. It handles one upstream transaction at a time. For each transaction it looks at the requested transfer size and picks one of two paths.

If the transfer size is 4 bytes or less, the request goes downstream unchanged. The data channel is then joined combinationally. The right 32-bit half of the 64-bit data and strobe bus is picked on every beat from bit 2 of that beat's address.

An 8-byte request takes the other path. It is rewritten as one or more 4-byte-wide INCR bursts, and every input beat is sent as two output beats. Downstream responses are folded into a single upstream response.

Top module: `axi_wr_narrow64to32`

## Requirements
- R1: When the incoming size is 0, 1 or 2, exactly one downstream request is issued. Its address, length, size and burst (FIXED=0, INCR=1, WRAP=2) are equal to the incoming ones.
- R2: A request accepted at clock edge k is offered downstream from edge k on. With the downstream side always ready, the first downstream data beat transfers at edge k+2. The request fields stay stable while they wait for the ready.
- R3: On the pass-through path, each output beat carries data bits [63:32] and strobes [7:4] when bit 2 of that beat's address is 1. Otherwise it carries bits [31:0] and strobes [3:0]. Beat addresses follow the burst rules: FIXED repeats the start address; INCR goes from the size-aligned start address in steps of the transfer size; WRAP wraps inside a window of (length+1)·size bytes.
- R4: On the 8-byte path, each input beat gives two output beats: first bits [31:0] with strobes [3:0], then bits [63:32] with strobes [7:4]. An input beat is consumed only together with its second output beat, so it completes no earlier than edge k+3.
- R5: An 8-byte INCR burst of n beats is issued as INCR size-2 requests. Each request covers at most 128 input beats, with length 2·c−1 for a piece of c beats. Each piece starts at the start address plus 8 times the index of its first input beat.
- R6: An 8-byte FIXED burst of n beats is issued as n INCR size-2 requests of length 1, all at the start address.
- R7: An 8-byte WRAP burst is issued as one INCR size-2 request of length 1 per input beat, at that beat's wrapped address.
- R8: The output last flag is high only on the final beat of each generated request. On the pass-through path it follows the incoming last flag.
- R9: Exactly one upstream response is returned per accepted transaction. It carries the numerically largest code among the downstream responses (OKAY=0, EXOKAY=1, SLVERR=2, DECERR=3), and it stays stable until it is taken.
- R10: The upstream address ready is low from acceptance until the upstream response is taken. The upstream data ready is low outside the data phase.
- R11: After reset the upstream address ready is high, and every valid output and the upstream data ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awlen | input | 8 | Upstream burst length minus one |
| s_awsize | input | 3 | Upstream transfer size (log2 bytes) |
| s_awburst | input | 2 | Upstream burst type |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wdata | input | 64 | Upstream write data |
| s_wstrb | input | 8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_bresp | output | 2 | Merged response code |
| s_bvalid | output | 1 | Upstream response valid |
| s_bready | input | 1 | Upstream response ready |
| m_awaddr | output | ADDR_W | Downstream write address |
| m_awlen | output | 8 | Downstream burst length minus one |
| m_awsize | output | 3 | Downstream transfer size |
| m_awburst | output | 2 | Downstream burst type |
| m_awvalid | output | 1 | Downstream address valid |
| m_awready | input | 1 | Downstream address ready |
| m_wdata | output | 32 | Downstream write data |
| m_wstrb | output | 4 | Downstream byte strobes |
| m_wlast | output | 1 | Downstream last beat |
| m_wvalid | output | 1 | Downstream data valid |
| m_wready | input | 1 | Downstream data ready |
| m_bresp | input | 2 | Downstream response code |
| m_bvalid | input | 1 | Downstream response valid |
| m_bready | output | 1 | Downstream response ready |

## Verification
The bench builds the block with its defaults: a 32-bit address and a 256-beat downstream limit, which gives a 128-beat piece size. With these values, directed INCR bursts of 129 and 256 wide beats reach the piece-split boundary, and the split can be seen at the ports. Random transactions mix every size with FIXED, INCR and WRAP bursts, and random ready and response patterns on both sides. Two runs with the downstream side always ready measure the start-up latency of each path.

// File: rtl/axi_wr_narrow64to32.sv
module axi_wr_narrow64to32 #(
  parameter int ADDR_W  = 32,
  parameter int OUT_MAX = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic [7:0]        s_awlen,
  input  logic [2:0]        s_awsize,
  input  logic [1:0]        s_awburst,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [63:0]       s_wdata,
  input  logic [7:0]        s_wstrb,
  input  logic              s_wlast,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [7:0]        m_awlen,
  output logic [2:0]        m_awsize,
  output logic [1:0]        m_awburst,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready
);
  localparam logic [8:0] CHUNK = 9'(OUT_MAX / 2);
  localparam logic [1:0] BT_FIXED = 2'd0, BT_INCR = 2'd1, BT_WRAP = 2'd2;

  typedef enum logic [2:0] {ST_IDLE, ST_AW, ST_DATA, ST_RESP, ST_UP} st_t;
  st_t st;

  logic [ADDR_W-1:0] a_base;
  logic [7:0]        a_len;
  logic [2:0]        a_size;
  logic [1:0]        a_burst;
  logic              wide, half;
  logic [8:0]        gidx, sub_n, sub_i;
  logic [1:0]        acc;

  logic [ADDR_W-1:0] off, wmask, amask, cur_addr;
  logic [8:0]        remain, next_n, nm1;
  logic              upper, last_in;

  assign off    = ADDR_W'(gidx) << a_size;
  assign wmask  = ((ADDR_W'(a_len) + ADDR_W'(1)) << a_size) - ADDR_W'(1);
  assign amask  = (ADDR_W'(1) << a_size) - ADDR_W'(1);

  always_comb begin
    case (a_burst)
      BT_FIXED: cur_addr = a_base;
      BT_WRAP:  cur_addr = (a_base & ~wmask) | ((a_base + off) & wmask);
      default:  cur_addr = (gidx == 9'd0) ? a_base : (a_base & ~amask) + off;
    endcase
  end

  assign remain = {1'b0, a_len} + 9'd1 - gidx;
  assign next_n = !wide ? remain :
                  (a_burst == BT_INCR) ? ((remain > CHUNK) ? CHUNK : remain) : 9'd1;
  assign nm1    = next_n - 9'd1;

  assign s_awready = (st == ST_IDLE);
  assign m_awvalid = (st == ST_AW);
  assign m_awaddr  = cur_addr;
  assign m_awlen   = wide ? {nm1[6:0], 1'b1} : a_len;
  assign m_awsize  = wide ? 3'd2 : a_size;
  assign m_awburst = wide ? BT_INCR : a_burst;

  assign upper    = wide ? half : cur_addr[2];
  assign last_in  = (sub_i == sub_n - 9'd1);
  assign m_wdata  = upper ? s_wdata[63:32] : s_wdata[31:0];
  assign m_wstrb  = upper ? s_wstrb[7:4]   : s_wstrb[3:0];
  assign m_wvalid = (st == ST_DATA) & s_wvalid;
  assign s_wready = (st == ST_DATA) & m_wready & (!wide | half);
  assign m_wlast  = wide ? (half & last_in) : s_wlast;

  assign m_bready = (st == ST_RESP);
  assign s_bvalid = (st == ST_UP);
  assign s_bresp  = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      a_base  <= '0;
      a_len   <= '0;
      a_size  <= '0;
      a_burst <= '0;
      wide    <= 1'b0;
      half    <= 1'b0;
      gidx    <= '0;
      sub_n   <= '0;
      sub_i   <= '0;
      acc     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (s_awvalid) begin
          a_base  <= s_awaddr;
          a_len   <= s_awlen;
          a_size  <= s_awsize;
          a_burst <= s_awburst;
          wide    <= (s_awsize == 3'd3);
          gidx    <= '0;
          acc     <= '0;
          st      <= ST_AW;
        end
        ST_AW: if (m_awready) begin
          sub_n <= next_n;
          sub_i <= '0;
          half  <= 1'b0;
          st    <= ST_DATA;
        end
        ST_DATA: if (m_wvalid && m_wready) begin
          if (wide) half <= ~half;
          if (s_wready) begin
            gidx  <= gidx + 9'd1;
            sub_i <= sub_i + 9'd1;
          end
          if (m_wlast) st <= ST_RESP;
        end
        ST_RESP: if (m_bvalid) begin
          if (m_bresp > acc) acc <= m_bresp;
          st <= (gidx <= {1'b0, a_len}) ? ST_AW : ST_UP;
        end
        ST_UP: if (s_bready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

module axi_wr_narrow64to32_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic [1:0]        s_bresp,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic [7:0]        m_awlen,
  input logic [2:0]        m_awsize,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_wlast,
  input logic              m_bready
);
  AST_AW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s_awvalid && s_awready |=> m_awvalid); // R2
  AST_MAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen) && $stable(m_awsize)); // R2
  AST_OUT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> m_awsize <= 3'd2); // R5
  AST_IN_WITH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s_wvalid && s_wready |-> m_wvalid && m_wready); // R4
  AST_LAST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && m_wready && m_wlast |=> !m_wvalid); // R8
  AST_BUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp)); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid || m_wvalid || m_bready || s_bvalid |-> !s_awready); // R10
endmodule

bind axi_wr_narrow64to32 axi_wr_narrow64to32_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready), .s_bresp(s_bresp), .s_bvalid(s_bvalid),
  .s_bready(s_bready), .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_wvalid(m_wvalid),
  .m_wready(m_wready), .m_wlast(m_wlast), .m_bready(m_bready)
);

// File: tb/sim_axi_wr_narrow64to32.sv
module sim_axi_wr_narrow64to32;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [31:0] s_awaddr = 0; logic [7:0] s_awlen = 0; logic [2:0] s_awsize = 0;
  logic [1:0] s_awburst = 0; logic s_awvalid = 0, s_awready;
  logic [63:0] s_wdata = 0; logic [7:0] s_wstrb = 0; logic s_wlast = 0, s_wvalid = 0, s_wready;
  logic [1:0] s_bresp; logic s_bvalid, s_bready = 0;
  logic [31:0] m_awaddr; logic [7:0] m_awlen; logic [2:0] m_awsize; logic [1:0] m_awburst;
  logic m_awvalid, m_awready;
  logic [31:0] m_wdata; logic [3:0] m_wstrb; logic m_wlast, m_wvalid, m_wready;
  logic [1:0] m_bresp; logic m_bvalid, m_bready;

  axi_wr_narrow64to32 u0 (.*);

  typedef struct packed {logic [31:0] a; logic [7:0] l; logic [2:0] s; logic [1:0] b;} aw_t;
  typedef struct packed {logic [31:0] d; logic [3:0] s; logic l;} w_t;
  aw_t exp_aw[$], got_aw[$];
  w_t  exp_w[$],  got_w[$];
  logic [1:0] resp_q[$];

  int nchk = 0, nfail = 0, cyc = 0, pend = 0;
  int first_maw, first_mw, first_sw, aw_cyc;
  bit fast = 0, b_taken = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  function automatic logic [31:0] baddr(logic [31:0] a, logic [7:0] l, logic [2:0] s, logic [1:0] b, int i);
    logic [31:0] off = 32'(i) << s;
    logic [31:0] wm  = ((32'(l) + 32'd1) << s) - 32'd1;
    logic [31:0] am  = (32'd1 << s) - 32'd1;
    if (b == 2'd0) return a;
    if (b == 2'd2) return (a & ~wm) | ((a + off) & wm);
    return (i == 0) ? a : (a & ~am) + off;
  endfunction

  // downstream responder
  initial begin
    m_awready = 0; m_wready = 0; m_bvalid = 0; m_bresp = 0;
    forever begin
      @(negedge clk);
      m_awready = fast || ($urandom % 4 != 0);
      m_wready  = fast || ($urandom % 4 != 0);
      if (b_taken) begin m_bvalid = 0; b_taken = 0; end
      if (!m_bvalid && pend > 0) begin
        m_bvalid = 1;
        m_bresp = (resp_q.size() > 0) ? resp_q.pop_front() : 2'd0;
        pend--;
      end
      #2;
      if (rst_n) begin
        if (m_awvalid && m_awready) begin
          got_aw.push_back({m_awaddr, m_awlen, m_awsize, m_awburst});
          if (first_maw < 0) first_maw = cyc;
        end
        if (m_wvalid && m_wready) begin
          got_w.push_back({m_wdata, m_wstrb, m_wlast});
          if (first_mw < 0) first_mw = cyc;
          if (m_wlast) pend++;
        end
        if (m_bvalid && m_bready) b_taken = 1;
      end
    end
  end

  task automatic run_txn(input logic [31:0] addr, input logic [7:0] len, input logic [2:0] size,
                         input logic [1:0] burst, input logic [63:0] d0, input bit lat);
    logic [63:0] dq[$]; logic [7:0] sq[$];
    logic [1:0] exp_r = 0, got_r = 0;
    bit wide = (size == 3'd3);
    string atag, wtag;
    exp_aw.delete(); exp_w.delete(); got_aw.delete(); got_w.delete(); resp_q.delete();
    for (int i = 0; i <= int'(len); i++) begin
      dq.push_back(i == 0 ? d0 : {$urandom, $urandom});
      sq.push_back(8'($urandom));
    end
    if (!wide) begin
      exp_aw.push_back({addr, len, size, burst});
      for (int i = 0; i <= int'(len); i++) begin
        logic hi = baddr(addr, len, size, burst, i) >> 2;
        exp_w.push_back({hi ? dq[i][63:32] : dq[i][31:0], hi ? sq[i][7:4] : sq[i][3:0], i == int'(len)});
      end
      atag = "R1"; wtag = "R3 R8";
    end else begin
      int i = 0;
      while (i <= int'(len)) begin
        int c = (burst == 2'd1) ? ((int'(len) + 1 - i > 128) ? 128 : int'(len) + 1 - i) : 1;
        exp_aw.push_back({baddr(addr, len, size, burst, i), 8'(2 * c - 1), 3'd2, 2'd1});
        for (int j = 0; j < c; j++) begin
          exp_w.push_back({dq[i+j][31:0], sq[i+j][3:0], 1'b0});
          exp_w.push_back({dq[i+j][63:32], sq[i+j][7:4], j == c - 1});
        end
        i += c;
      end
      atag = (burst == 2'd1) ? "R5" : (burst == 2'd0) ? "R6" : "R7";
      wtag = "R4 R8";
    end
    foreach (exp_aw[k]) begin
      logic [1:0] r = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
      resp_q.push_back(r);
      if (r > exp_r) exp_r = r;
    end
    first_maw = -1; first_mw = -1; first_sw = -1; aw_cyc = -1;
    fork
      begin
        @(negedge clk);
        s_awaddr = addr; s_awlen = len; s_awsize = size; s_awburst = burst; s_awvalid = 1;
        #2;
        while (!s_awready) begin @(negedge clk); #2; end
        aw_cyc = cyc;
        @(negedge clk); s_awvalid = 0;
      end
      begin
        for (int i = 0; i <= int'(len); i++) begin
          @(negedge clk);
          s_wvalid = 1; s_wdata = dq[i]; s_wstrb = sq[i]; s_wlast = (i == int'(len));
          #2;
          while (!s_wready) begin @(negedge clk); #2; end
          if (i == 0) first_sw = cyc;
        end
        @(negedge clk); s_wvalid = 0; s_wlast = 0;
      end
    join
    begin
      bit busy_ok = 1;
      forever begin
        @(negedge clk);
        s_bready = fast || ($urandom % 2 == 0);
        #2;
        if (!s_bvalid && s_awready) busy_ok = 0;
        if (s_bvalid && s_bready) begin got_r = s_bresp; break; end
        if (s_bvalid && s_awready) busy_ok = 0;
      end
      check(busy_ok, "R10 awready low while busy", {63'd0, busy_ok}, 64'd1);
    end
    @(negedge clk); s_bready = 0; #2;
    check(!s_bvalid && s_awready, "R9 single response then idle", {62'd0, s_bvalid, s_awready}, 64'd1);
    check(got_r == exp_r, "R9 merged response", 64'(got_r), 64'(exp_r));
    check(got_aw.size() == exp_aw.size(), {atag, " request count"}, 64'(got_aw.size()), 64'(exp_aw.size()));
    begin
      int bad = -1;
      foreach (exp_aw[k]) if (bad < 0 && (k >= got_aw.size() || got_aw[k] != exp_aw[k])) bad = k;
      if (bad < 0) check(1, atag, 0, 0);
      else check(0, {atag, " request fields"}, bad < got_aw.size() ? 64'(got_aw[bad]) : 64'hdead, 64'(exp_aw[bad]));
    end
    check(got_w.size() == exp_w.size(), {wtag, " beat count"}, 64'(got_w.size()), 64'(exp_w.size()));
    begin
      int bad = -1;
      foreach (exp_w[k]) if (bad < 0 && (k >= got_w.size() || got_w[k] != exp_w[k])) bad = k;
      if (bad < 0) check(1, wtag, 0, 0);
      else check(0, {wtag, " beat data/strobe/last"}, bad < got_w.size() ? 64'(got_w[bad]) : 64'hdead, 64'(exp_w[bad]));
    end
    if (lat) begin
      check(first_maw == aw_cyc + 1, "R2 request latency", 64'(first_maw - aw_cyc), 64'd1);
      check(first_mw == aw_cyc + 2, "R2 first output beat latency", 64'(first_mw - aw_cyc), 64'd2);
      check(first_sw == aw_cyc + (wide ? 3 : 2), "R4 first input beat completion",
            64'(first_sw - aw_cyc), wide ? 64'd3 : 64'd2);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #2;
    check(s_awready && !s_wready && !m_awvalid && !m_wvalid && !s_bvalid && !m_bready, "R11 reset state",
          {58'd0, s_awready, s_wready, m_awvalid, m_wvalid, s_bvalid, m_bready}, 64'b100000);
    @(negedge clk); rst_n = 1;
    #2;
    check(s_awready && !s_wready, "R11 after release", {62'd0, s_awready, s_wready}, 64'b10);

    fast = 1;
    run_txn(32'h8000_0000, 8'd0, 3'd3, 2'd1, 64'h1234_5678_abcd_feed, 1);
    run_txn(32'h0000_1004, 8'd2, 3'd2, 2'd1, 64'h0, 1);
    fast = 0;
    run_txn(32'h0000_2000, 8'd255, 3'd3, 2'd1, 64'h1, 0);
    run_txn(32'h0000_3000, 8'd128, 3'd3, 2'd1, 64'h2, 0);
    run_txn(32'h0000_4040, 8'd3, 3'd3, 2'd0, 64'h3, 0);
    run_txn(32'h0000_5010, 8'd3, 3'd3, 2'd2, 64'h4, 0);
    run_txn(32'h0000_6006, 8'd5, 3'd1, 2'd1, 64'h5, 0);
    run_txn(32'h0000_7005, 8'd3, 3'd0, 2'd0, 64'h6, 0);
    run_txn(32'h0000_800c, 8'd3, 3'd2, 2'd2, 64'h7, 0);
    for (int t = 0; t < 40; t++) begin
      logic [2:0] sz = 3'($urandom % 4);
      logic [1:0] bt = 2'($urandom % 3);
      logic [7:0] ln = (bt == 2'd2) ? 8'((2 << ($urandom % 4)) - 1) : 8'($urandom % 16);
      logic [31:0] ad = $urandom & ~((32'd1 << sz) - 32'd1);
      run_txn(ad, ln, sz, bt, {$urandom, $urandom}, 0);
    end
    finish_run();
  end
endmodule